// File: doc/BRIEF.md
# Polled Serial Port Core with Banked Divisor

This block is a byte-wide serial port that software drives by polling. A CPU reaches eight registers through a small parallel bus made of a chip select, one-cycle read and write strobes, a 3-bit address and 8-bit data. Bytes written to the data register enter a transmit FIFO. A transmitter state machine sends each one as an 8N1 frame. A receiver state machine rebuilds incoming frames and queues them in a receive FIFO. Software reads that FIFO through the same data address.

A 16-bit divisor sets the bit rate. One bit lasts sixteen baud ticks, and one tick lasts `divisor` clock cycles. Bit 7 of the line control register is the bank bit. While it is set, addresses 0 and 1 reach the divisor bytes and no longer reach the data and interrupt-enable registers. Address 2 has two meanings. A read returns an identification byte. A write goes to FIFO control.

The transmitter walks IDLE → START → DATA → STOP → IDLE:
- IDLE→START happens when a baud tick arrives and the transmit FIFO holds a byte.
- START→DATA happens after 16 ticks.
- DATA→STOP happens after the 8th data bit has run for 16 ticks.
- STOP→IDLE happens after 16 ticks.

The receiver walks IDLE → START → DATA → STOP → IDLE:
- IDLE→START happens on a falling edge of the synchronised line.
- START→DATA happens at the 8th tick if the line is still low. START→IDLE happens at that tick if the line is high (a false start).
- DATA→STOP happens after the 8th mid-bit sample.
- STOP→IDLE happens at the mid-point of the stop bit, where the byte is delivered.

Top module: `sio_core`

## Requirements
- R1: After reset the line status register (address 5) reads 0x60, line control (address 3) reads 0x00, and `tx_out` is high.
- R2: With line control bit 7 set, addresses 0 and 1 write and read the divisor low and high bytes. Those accesses neither queue a byte for transmission nor change interrupt enable (address 1 with bit 7 clear, low 4 bits kept).
- R3: A read of address 2 returns {E,E,00000,1}, where E is the FIFO enable bit. A write to address 2 sets FIFO control and changes no other register.
- R4: FIFO control bit 1 empties the receive FIFO and bit 2 empties the transmit FIFO. Both act once and are not stored. A change of bit 0 (FIFO enable) empties both FIFOs.
- R5: Each frame is a low start bit, 8 data bits sent least significant bit first, and a high stop bit. Every bit lasts 16 × divisor clock cycles.
- R6: Each byte written once to address 0 with bit 7 clear is sent exactly once. No duplicate frame and no extra frame appear.
- R7: Line status bit 0 is 1 while the receive FIFO holds a byte. Reads of address 0 return bytes in arrival order. The bit goes to 0 when the last byte is read.
- R8: Line status bit 5 is 1 while the transmit FIFO can accept a byte. The FIFO holds 2^FIFO_AW bytes when enabled and 1 byte when disabled.
- R9: Line status bit 6 is 1 only when the transmit FIFO is empty and the transmitter is idle.
- R10: A low stop-bit sample sets line status bit 3. The byte is still delivered. A read of line status clears the bit.
- R11: A byte that arrives while the receive FIFO is full is dropped and sets line status bit 1. A read of line status clears the bit.
- R12: A divisor of 0 stops the baud ticks. While stopped, no frame starts and `tx_out` stays high.
- R13: Address 7 and address 4 (low 5 bits) read back what was written and have no other effect. Address 6 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high |
| rx_in | input | 1 | Serial input |
| tx_out | output | 1 | Serial output |

## Verification
The bench builds the core with FIFO_AW = 2, so each FIFO holds four bytes. The full-FIFO transmit state and receive overrun are reached after four or five frames. The bench programs a divisor of 2, so one bit lasts 32 cycles and one frame lasts 320 cycles. It also switches the divisor to 0 to freeze the transmitter while the FIFO is filled or cleared. The transmit output is looped to the receive input for the round-trip case. The bench drives the receive line directly to produce bad stop bits and overflow.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 16;
    localparam int TICKS  = 16;

    localparam logic [2:0] REG_DATA  = 3'd0;
    localparam logic [2:0] REG_IEN   = 3'd1;
    localparam logic [2:0] REG_IDF   = 3'd2;
    localparam logic [2:0] REG_LCTL  = 3'd3;
    localparam logic [2:0] REG_MCTL  = 3'd4;
    localparam logic [2:0] REG_LSTAT = 3'd5;
    localparam logic [2:0] REG_MSTAT = 3'd6;
    localparam logic [2:0] REG_SCR   = 3'd7;

    localparam int BANK_BIT = 7;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    dout,
    output logic [AW:0]   count,
    output logic          empty,
    output logic          full
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_push;
    logic          do_pop;

    assign empty   = (count == '0);
    assign full    = (count == DEPTH_V);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wptr] <= din;
    end

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full && !clr) |=> (count == $past(count))); // R8
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] divisor,
    input  logic          restart,
    output logic          tick
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] cnt;
    logic          active;
    logic          wrap;

    assign active = (divisor != '0);
    assign wrap   = ((cnt + ONE) >= divisor);
    assign tick   = active && !restart && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !active || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > ONE && !restart && $stable(divisor)) |=> !tick); // R5
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_pop,
    output logic       tx_out,
    output logic       idle
);
    tx_state_t  state;
    tx_state_t  next;
    logic [3:0] tcnt;
    logic [2:0] bcnt;
    logic [7:0] shreg;
    logic       bit_end;

    assign bit_end = tick && (tcnt == 4'd15);

    always_comb begin
        next = state;
        unique case (state)
            TX_IDLE:  if (tick && !fifo_empty)           next = TX_START;
            TX_START: if (bit_end)                       next = TX_DATA;
            TX_DATA:  if (bit_end && bcnt == 3'd7)       next = TX_STOP;
            TX_STOP:  if (bit_end)                       next = TX_IDLE;
            default:                                     next = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            tcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
        end else begin
            state <= next;
            if (state == TX_IDLE) begin
                tcnt <= '0;
                bcnt <= '0;
                if (fifo_pop) shreg <= fifo_data;
            end else if (tick) begin
                tcnt <= tcnt + 4'd1;
                if (state == TX_DATA && tcnt == 4'd15) begin
                    bcnt  <= bcnt + 3'd1;
                    shreg <= {1'b0, shreg[7:1]};
                end
            end
        end
    end

    always_comb begin
        fifo_pop = 1'b0;
        tx_out   = 1'b1;
        idle     = 1'b0;
        unique case (state)
            TX_IDLE: begin
                idle     = 1'b1;
                fifo_pop = tick && !fifo_empty;
            end
            TX_START: tx_out = 1'b0;
            TX_DATA:  tx_out = shreg[0];
            TX_STOP:  tx_out = 1'b1;
            default:  tx_out = 1'b1;
        endcase
    end

    AST_IDLE_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && !tick) |=> (state == TX_IDLE)); // R12
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_in,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_err
);
    rx_state_t  state;
    rx_state_t  next;
    logic [3:0] tcnt;
    logic [2:0] bcnt;
    logic [7:0] shreg;
    logic       sync1;
    logic       sync2;
    logic       prev;
    logic       fall;
    logic       mid_start;
    logic       bit_end;

    assign fall      = prev && !sync2;
    assign mid_start = tick && (tcnt == 4'd7);
    assign bit_end   = tick && (tcnt == 4'd15);

    always_comb begin
        next = state;
        unique case (state)
            RX_IDLE:  if (fall)                     next = RX_START;
            RX_START: if (mid_start)                next = sync2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bcnt == 3'd7)  next = RX_STOP;
            RX_STOP:  if (bit_end)                  next = RX_IDLE;
            default:                                next = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            prev  <= 1'b1;
            state <= RX_IDLE;
            tcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
        end else begin
            sync1 <= rx_in;
            sync2 <= sync1;
            prev  <= sync2;
            state <= next;
            if (next != state || state == RX_IDLE) begin
                tcnt <= '0;
            end else if (tick) begin
                tcnt <= tcnt + 4'd1;
            end
            if (state != RX_DATA) begin
                bcnt <= '0;
            end else if (bit_end) begin
                bcnt  <= bcnt + 3'd1;
                shreg <= {sync2, shreg[7:1]};
            end
        end
    end

    always_comb begin
        byte_valid = 1'b0;
        frame_err  = 1'b0;
        byte_data  = shreg;
        unique case (state)
            RX_IDLE, RX_START, RX_DATA: begin
                byte_valid = 1'b0;
            end
            RX_STOP: begin
                byte_valid = bit_end;
                frame_err  = bit_end && !sync2;
            end
            default: byte_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sio_core.sv
module sio_core
    import sio_pkg::*;
#(
    parameter int FIFO_AW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rd,
    input  logic       wr,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rx_in,
    output logic       tx_out
);
    logic [7:0]       lcr;
    logic [3:0]       ier;
    logic [4:0]       mcr;
    logic [7:0]       scr;
    logic [DIV_W-1:0] divisor;
    logic             fifo_en;
    logic             lsr_oe;
    logic             lsr_fe;

    logic wr_en, rd_en, bank;
    logic tx_wr, rx_rd, lsr_rd, fcr_wr, div_wr;
    logic tx_clr, rx_clr;
    logic tick;

    logic [7:0]     tx_dout, rx_dout, rx_byte;
    logic [FIFO_AW:0] tx_count, rx_count;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic tx_full_eff, rx_full_eff;
    logic tx_pop, tx_idle;
    logic rx_valid, rx_ferr, rx_ovr_ev;
    logic thre, temt;
    logic [7:0] lsr;

    assign wr_en  = cs && wr;
    assign rd_en  = cs && rd;
    assign bank   = lcr[BANK_BIT];
    assign tx_wr  = wr_en && addr == REG_DATA && !bank;
    assign rx_rd  = rd_en && addr == REG_DATA && !bank;
    assign lsr_rd = rd_en && addr == REG_LSTAT;
    assign fcr_wr = wr_en && addr == REG_IDF;
    assign div_wr = wr_en && bank && (addr == REG_DATA || addr == REG_IEN);
    assign tx_clr = fcr_wr && (wdata[2] || wdata[0] != fifo_en);
    assign rx_clr = fcr_wr && (wdata[1] || wdata[0] != fifo_en);

    assign tx_full_eff = fifo_en ? tx_full : (tx_count != '0);
    assign rx_full_eff = fifo_en ? rx_full : (rx_count != '0);
    assign rx_ovr_ev   = rx_valid && rx_full_eff;

    assign thre = !tx_full_eff;
    assign temt = tx_empty && tx_idle;
    assign lsr  = {1'b0, temt, thre, 1'b0, lsr_fe, 1'b0, lsr_oe, !rx_empty};

    sio_baud #(.DW(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .restart (div_wr),
        .tick    (tick)
    );

    sio_fifo #(.AW(FIFO_AW)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_wr && !tx_full_eff),
        .din   (wdata),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_count),
        .empty (tx_empty),
        .full  (tx_full)
    );

    sio_fifo #(.AW(FIFO_AW)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_valid && !rx_full_eff),
        .din   (rx_byte),
        .pop   (rx_rd),
        .dout  (rx_dout),
        .count (rx_count),
        .empty (rx_empty),
        .full  (rx_full)
    );

    sio_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_dout),
        .fifo_pop   (tx_pop),
        .tx_out     (tx_out),
        .idle       (tx_idle)
    );

    sio_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rx_in      (rx_in),
        .byte_valid (rx_valid),
        .byte_data  (rx_byte),
        .frame_err  (rx_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr     <= '0;
            ier     <= '0;
            mcr     <= '0;
            scr     <= '0;
            divisor <= '0;
            fifo_en <= 1'b0;
            lsr_oe  <= 1'b0;
            lsr_fe  <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    REG_DATA:  if (bank) divisor[7:0] <= wdata;
                    REG_IEN:   if (bank) divisor[15:8] <= wdata;
                               else      ier <= wdata[3:0];
                    REG_IDF:   fifo_en <= wdata[0];
                    REG_LCTL:  lcr <= wdata;
                    REG_MCTL:  mcr <= wdata[4:0];
                    REG_SCR:   scr <= wdata;
                    default:   ;
                endcase
            end
            if (rx_ovr_ev)   lsr_oe <= 1'b1;
            else if (lsr_rd) lsr_oe <= 1'b0;
            if (rx_ferr)     lsr_fe <= 1'b1;
            else if (lsr_rd) lsr_fe <= 1'b0;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            unique case (addr)
                REG_DATA:  rdata = bank ? divisor[7:0] : rx_dout;
                REG_IEN:   rdata = bank ? divisor[15:8] : {4'h0, ier};
                REG_IDF:   rdata = {fifo_en, fifo_en, 5'b00000, 1'b1};
                REG_LCTL:  rdata = lcr;
                REG_MCTL:  rdata = {3'b000, mcr};
                REG_LSTAT: rdata = lsr;
                REG_MSTAT: rdata = 8'h00;
                REG_SCR:   rdata = scr;
                default:   rdata = 8'h00;
            endcase
        end
    end

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R6
    AST_TEMT_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> tx_out); // R9
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ferr |=> lsr_fe); // R10
    AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr_ev |=> lsr_oe); // R11
endmodule

// File: tb/sio_core_test.sv
module sio_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tx_out;
    logic       rx_drv = 1'b1;
    logic       loop = 1'b0;
    logic       rx_in;

    int nchk = 0;
    int nfail = 0;
    int bit_clks = 32;
    logic [7:0] mon_byte [0:63];
    int mon_cnt = 0;
    int mon_stop_err = 0;

    assign rx_in = loop ? tx_out : rx_drv;

    always #10 clk = ~clk;

    sio_core #(.FIFO_AW(2)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .rx_in(rx_in), .tx_out(tx_out)
    );

    // serial monitor on tx_out
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && tx_out === 1'b0) begin
                repeat (bit_clks / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (bit_clks) @(negedge clk);
                    b[i] = tx_out;
                end
                repeat (bit_clks) @(negedge clk);
                if (tx_out !== 1'b1) mon_stop_err++;
                if (mon_cnt < 64) mon_byte[mon_cnt] = b;
                mon_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic set_div(input logic [7:0] v);
        bus_wr(3'd3, 8'h83);
        bus_wr(3'd0, v);
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd3, 8'h03);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            repeat (bit_clks) @(negedge clk);
        end
        rx_drv = stop;
        repeat (bit_clks) @(negedge clk);
        rx_drv = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 tx_out idle", {31'd0, tx_out}, 32'd1);
        bus_rd(3'd5, d); chk("R1 line status", {24'd0, d}, 32'h60);
        bus_rd(3'd3, d); chk("R1 line control", {24'd0, d}, 32'h00);
    endtask

    task automatic t_scratch;
        logic [7:0] d;
        bus_wr(3'd7, 8'h5A);
        bus_wr(3'd4, 8'hFF);
        bus_rd(3'd7, d); chk("R13 scratch", {24'd0, d}, 32'h5A);
        bus_rd(3'd4, d); chk("R13 modem ctl", {24'd0, d}, 32'h1F);
        bus_rd(3'd6, d); chk("R13 modem status", {24'd0, d}, 32'h00);
        bus_rd(3'd5, d); chk("R13 status untouched", {24'd0, d}, 32'h60);
        chk("R13 line untouched", {31'd0, tx_out}, 32'd1);
    endtask

    task automatic t_ident;
        logic [7:0] d;
        bus_wr(3'd2, 8'h07);
        bus_rd(3'd2, d); chk("R3 id fifo on", {24'd0, d}, 32'hC1);
        bus_wr(3'd2, 8'h00);
        bus_rd(3'd2, d); chk("R3 id fifo off", {24'd0, d}, 32'h01);
        bus_rd(3'd3, d); chk("R3 lcr untouched", {24'd0, d}, 32'h00);
        bus_wr(3'd2, 8'h07);
        bus_rd(3'd2, d); chk("R3 id restored", {24'd0, d}, 32'hC1);
    endtask

    task automatic t_bank;
        logic [7:0] d;
        int base;
        base = mon_cnt;
        bus_wr(3'd1, 8'h05);
        bus_wr(3'd3, 8'h83);
        bus_wr(3'd0, 8'h02);
        bus_wr(3'd1, 8'h00);
        bus_rd(3'd0, d); chk("R2 divisor low", {24'd0, d}, 32'h02);
        bus_rd(3'd1, d); chk("R2 divisor high", {24'd0, d}, 32'h00);
        bus_wr(3'd3, 8'h03);
        bus_rd(3'd1, d); chk("R2 ier kept", {24'd0, d}, 32'h05);
        bus_rd(3'd5, d); chk("R2 nothing queued", {24'd0, d}, 32'h60);
        repeat (400) @(negedge clk);
        chk("R2 no frame sent", mon_cnt - base, 32'd0);
    endtask

    task automatic t_loop;
        logic [7:0] d;
        logic [7:0] v [4];
        int base;
        v[0] = 8'h61; v[1] = 8'h55; v[2] = 8'h00; v[3] = 8'h80;
        base = mon_cnt;
        loop = 1'b1;
        for (int i = 0; i < 4; i++) bus_wr(3'd0, v[i]);
        repeat (4 * 10 * 32 + 300) @(negedge clk);
        chk("R6 frame count", mon_cnt - base, 32'd4);
        chk("R5 stop bits", mon_stop_err, 32'd0);
        for (int i = 0; i < 4; i++) chk("R5 frame byte", {24'd0, mon_byte[base + i]}, {24'd0, v[i]});
        for (int i = 0; i < 4; i++) begin
            bus_rd(3'd5, d); chk("R7 data ready", {31'd0, d[0]}, 32'd1);
            bus_rd(3'd0, d); chk("R7 byte order", {24'd0, d}, {24'd0, v[i]});
        end
        bus_rd(3'd5, d); chk("R7 drained", {24'd0, d}, 32'h60);
        loop = 1'b0;
    endtask

    task automatic t_halt_fill;
        logic [7:0] d;
        logic [7:0] v [4];
        int base;
        int low;
        v[0] = 8'h41; v[1] = 8'hFF; v[2] = 8'h3C; v[3] = 8'h0F;
        base = mon_cnt;
        low = 0;
        set_div(8'h00);
        bus_wr(3'd0, v[0]);
        bus_rd(3'd5, d); chk("R8 room left", {24'd0, d}, 32'h20);
        for (int i = 1; i < 4; i++) bus_wr(3'd0, v[i]);
        bus_rd(3'd5, d); chk("R8 full", {24'd0, d}, 32'h00);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_out !== 1'b1) low++;
        end
        chk("R12 halted line high", low, 32'd0);
        chk("R12 no frame halted", mon_cnt - base, 32'd0);
        set_div(8'h02);
        repeat (4 * 10 * 32 + 300) @(negedge clk);
        chk("R6 released frames", mon_cnt - base, 32'd4);
        for (int i = 0; i < 4; i++) chk("R6 released byte", {24'd0, mon_byte[base + i]}, {24'd0, v[i]});
        bus_rd(3'd5, d); chk("R9 empty after send", {24'd0, d}, 32'h60);
    endtask

    task automatic t_tx_clear;
        logic [7:0] d;
        int base;
        base = mon_cnt;
        set_div(8'h00);
        for (int i = 0; i < 3; i++) bus_wr(3'd0, 8'h10 + 8'(i));
        bus_rd(3'd5, d); chk("R9 not empty", {24'd0, d}, 32'h20);
        bus_wr(3'd2, 8'h05);
        bus_rd(3'd5, d); chk("R4 tx cleared", {24'd0, d}, 32'h60);
        bus_wr(3'd2, 8'h00);
        bus_wr(3'd0, 8'h99);
        bus_rd(3'd5, d); chk("R8 single holding", {24'd0, d}, 32'h00);
        bus_wr(3'd2, 8'h01);
        bus_rd(3'd5, d); chk("R4 enable change clears", {24'd0, d}, 32'h60);
        set_div(8'h02);
        repeat (800) @(negedge clk);
        chk("R4 nothing sent", mon_cnt - base, 32'd0);
    endtask

    task automatic t_rx_clear;
        logic [7:0] d;
        send_rx(8'hA1, 1'b1);
        send_rx(8'hB2, 1'b1);
        bus_rd(3'd5, d); chk("R7 bytes waiting", {24'd0, d}, 32'h61);
        bus_wr(3'd2, 8'h03);
        bus_rd(3'd5, d); chk("R4 rx cleared", {24'd0, d}, 32'h60);
        send_rx(8'hC3, 1'b1);
        bus_rd(3'd5, d); chk("R4 clear not sticky", {24'd0, d}, 32'h61);
        bus_rd(3'd0, d); chk("R4 new byte", {24'd0, d}, 32'hC3);
    endtask

    task automatic t_framing;
        logic [7:0] d;
        send_rx(8'h3C, 1'b0);
        bus_rd(3'd5, d); chk("R10 framing set", {24'd0, d}, 32'h69);
        bus_rd(3'd5, d); chk("R10 framing cleared", {24'd0, d}, 32'h61);
        bus_rd(3'd0, d); chk("R10 byte kept", {24'd0, d}, 32'h3C);
    endtask

    task automatic t_overrun;
        logic [7:0] d;
        for (int i = 1; i <= 5; i++) send_rx(8'(i * 17), 1'b1);
        bus_rd(3'd5, d); chk("R11 overrun set", {24'd0, d}, 32'h63);
        bus_rd(3'd5, d); chk("R11 overrun cleared", {24'd0, d}, 32'h61);
        for (int i = 1; i <= 4; i++) begin
            bus_rd(3'd0, d); chk("R11 kept bytes", {24'd0, d}, 32'(i * 17));
        end
        bus_rd(3'd5, d); chk("R11 drained", {24'd0, d}, 32'h60);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_scratch();
        t_ident();
        t_bank();
        t_loop();
        t_halt_fill();
        t_tx_clear();
        t_rx_clear();
        t_framing();
        t_overrun();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule